// File: doc/BRIEF.md
# Synchronized Multi-Key Scan Sequencer

This block drives a capacitive sensor front end through a fixed series of key channels. It starts at key 0 and ends at the last key. Each key owns one timeslot, and a one-cycle burst-start pulse opens the slot. The slot length comes from a 3-bit spacing code, counted in half-millisecond units from a clock prescaler. If the burst for a key is still running when its slot runs out, the slot grows until the burst-done strobe arrives. The next key then starts on the following cycle.

Several devices can begin each scan at the same moment. In level mode, all devices share an open-drain sync line. Each device pulls the line low while it measures any key other than key 0. After its last key, it lets the line go and waits until it sees the line high. That happens only when every device on the line has finished. In edge mode, a rising edge on the sync input starts the scan, and a steady high level does not. In both modes, the communication-busy flag holds off the start of key 0 for as long as it is asserted.

Top module: `key_scan_sequencer`

## Requirements
- R1: Keys start in ascending order, 0 up to NUM_KEYS-1 (9 by default). After the last key's slot ends, the sequencer idles with key index 0 and issues no burst until the next start condition.
- R2: When the burst finishes inside its slot, the time from one burst-start pulse to the next is UNITS×TICK_DIV clock cycles. UNITS depends on the spacing code: code 0→4, 1→5, 2→6, 3→7, 4→8, 5→10, 6→12, 7→14. Each unit is 0.5 ms, so the codes give 2.0, 2.5, 3.0, 3.5, 4.0, 5.0, 6.0 and 7.0 ms. The code is sampled when the slot starts.
- R3: If burst-done arrives at cycle offset d ≥ UNITS×TICK_DIV, counted from the burst-start cycle at offset 0, the next burst-start comes at offset d+1.
- R4: In level mode (edgeMode=0), syncPullLow is 1 exactly while a key other than key 0 is in its slot. It is 0 during key 0 and while idle.
- R5: In level mode, key 0 starts only while the sync line reads high. burstStart rises on the third clock edge after the line goes high, counting the two-flop synchronizer. A line held low by another device holds the start off indefinitely.
- R6: In edge mode (edgeMode=1), key 0 starts on the third clock edge after a rising edge of syncIn. A line that stays high, or an edge during a scan, does not start a scan, and syncPullLow stays 0.
- R7: While commBusy is 1, key 0 does not start. A start condition that is pending (line high, or an edge seen while idle) starts key 0 on the clock edge that ends the first cycle with commBusy low.
- R8: After reset the sequencer idles, with keyIdx=0, burstStart=0 and syncPullLow=0.
- R9: burstStart is high for exactly one cycle per slot.
- R10: syncPullLow is registered and changes only on a slot boundary: at a burst start, or at the end of the last key's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| edgeMode | input | 1 | 0 = shared-line level sync, 1 = rising-edge sync |
| spacingCode | input | 3 | Timeslot length code |
| burstDone | input | 1 | One-cycle strobe marking the end of the current burst |
| commBusy | input | 1 | Serial traffic in progress; defers the start of key 0 |
| syncIn | input | 1 | Sync line as read at the pin |
| keyIdx | output | KEY_W | Key whose slot is running (0 while idle) |
| burstStart | output | 1 | One-cycle pulse at the start of each timeslot |
| syncPullLow | output | 1 | Enable for the open-drain pull-down on the sync line |

## Verification
The slot timing is driven with randomly chosen spacing codes and random burst-done offsets. Some offsets fall inside the slot and some lie past its end, so the measured intervals separate the fixed lookup length (R2) from the overrun stretch (R3). In level mode, a second device is modelled as an extra pull-down on the line. Holding it low past the end of a scan, and then releasing it, checks the synchronizer delay and the wait for the real line level. Edge mode is run with the line held high across whole scans and with toggles during a scan, which shows that only a rising edge while idle starts key 0. A busy flag held over a pending level or edge start shows the deferral and the one-cycle restart.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  localparam int UNIT_W = 4;

  typedef enum logic {ST_WAIT = 1'b0, ST_RUN = 1'b1} scanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic slotStart;
    logic idle;
  } scanCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic slotEnd;
    logic syncHigh;
    logic syncRise;
  } scanStat_t;

  // half-millisecond units per timeslot for a spacing code
  function automatic logic [UNIT_W-1:0] unitsForCode(input logic [2:0] code);
    if (code < 3'd5) unitsForCode = {1'b0, code} + 4'd4;
    else             unitsForCode = {code, 1'b0};
  endfunction

endpackage

// File: rtl/scan_timer_dp.sv
module scan_timer_dp
  import scan_seq_pkg::*;
#(
  parameter int TICK_DIV = 125000
) (
  input  logic       clk,
  input  logic       rstN,
  input  scanCtrl_t  ctrl,
  input  logic [2:0] spacingCode,
  input  logic       burstDone,
  input  logic       syncIn,
  output scanStat_t  stat
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic [UNIT_W-1:0] unitTarget;
  logic              burstActive;
  logic              timeUp;
  logic              syncS1, syncS2, syncS3;
  logic              unitTick;
  logic              lastTick;
  logic              burstBusy;

  assign unitTick  = !ctrl.idle && (preCnt == PRE_LAST);
  assign lastTick  = unitTick && (unitCnt == UNIT_W'(unitTarget - 4'd1));
  assign burstBusy = burstActive && !burstDone;

  assign stat.slotEnd  = (lastTick || timeUp) && !burstBusy;
  assign stat.syncHigh = syncS2;
  assign stat.syncRise = syncS2 && !syncS3;

  // two-flop synchronizer plus history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncS1 <= 1'b0;
      syncS2 <= 1'b0;
      syncS3 <= 1'b0;
    end else begin
      syncS1 <= syncIn;
      syncS2 <= syncS1;
      syncS3 <= syncS2;
    end
  end

  // slot timer: prescaler restarts at every slot start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt      <= '0;
      unitCnt     <= '0;
      unitTarget  <= unitsForCode(3'd2);
      burstActive <= 1'b0;
      timeUp      <= 1'b0;
    end else if (ctrl.slotStart) begin
      preCnt      <= '0;
      unitCnt     <= '0;
      unitTarget  <= unitsForCode(spacingCode);
      burstActive <= 1'b1;
      timeUp      <= 1'b0;
    end else begin
      if (burstDone) burstActive <= 1'b0;
      if (lastTick && burstBusy) timeUp <= 1'b1;
      if (!ctrl.idle) begin
        if (unitTick) begin
          preCnt  <= '0;
          unitCnt <= unitCnt + 4'd1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  // R2
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.slotStart |=> (preCnt == '0 && unitCnt == '0));

  // R3
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeUp && burstActive && !burstDone) |=> !burstActive || timeUp);

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NUM_KEYS = 10,
  parameter int KEY_W    = $clog2(NUM_KEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             edgeMode,
  input  logic             commBusy,
  input  scanStat_t        stat,
  output scanCtrl_t        ctrl,
  output logic [KEY_W-1:0] keyIdx,
  output logic             burstStart,
  output logic             syncPullLow
);

  localparam logic [KEY_W-1:0] LAST_KEY = KEY_W'(NUM_KEYS - 1);

  scanState_t state;
  logic       edgeArmed;
  logic       startReq;
  logic       nextKey;

  assign startReq = (state == ST_WAIT) && !commBusy &&
                    (edgeMode ? (stat.syncRise || edgeArmed) : stat.syncHigh);
  assign nextKey  = (state == ST_RUN) && stat.slotEnd && (keyIdx != LAST_KEY);

  assign ctrl.slotStart = startReq || nextKey;
  assign ctrl.idle      = (state == ST_WAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_WAIT;
      keyIdx      <= '0;
      burstStart  <= 1'b0;
      syncPullLow <= 1'b0;
      edgeArmed   <= 1'b0;
    end else begin
      burstStart <= 1'b0;
      if (state == ST_WAIT && edgeMode)
        edgeArmed <= (edgeArmed || stat.syncRise) && !startReq;
      else
        edgeArmed <= 1'b0;

      if (startReq) begin
        state       <= ST_RUN;
        keyIdx      <= '0;
        burstStart  <= 1'b1;
        syncPullLow <= 1'b0;
      end else if (state == ST_RUN && stat.slotEnd) begin
        if (keyIdx == LAST_KEY) begin
          state       <= ST_WAIT;
          keyIdx      <= '0;
          syncPullLow <= 1'b0;
        end else begin
          keyIdx      <= keyIdx + 1'b1;
          burstStart  <= 1'b1;
          syncPullLow <= !edgeMode;
        end
      end
    end
  end

  // R1
  key_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextKey |=> (burstStart && keyIdx == KEY_W'($past(keyIdx) + 1'b1)));

  // R1
  scan_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stat.slotEnd && keyIdx == LAST_KEY) |=>
      (state == ST_WAIT && !burstStart && keyIdx == '0));

  // R3
  no_early_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !stat.slotEnd) |=> !burstStart);

  // R4
  pull_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPullLow |-> (state == ST_RUN && keyIdx != '0));

  // R7
  busy_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && commBusy) |=> !burstStart);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> !burstStart);

  // R10
  pull_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(syncPullLow) |-> $past(state == ST_RUN && stat.slotEnd));

endmodule

// File: rtl/key_scan_sequencer.sv
module key_scan_sequencer
  import scan_seq_pkg::*;
#(
  parameter int TICK_DIV = 125000,
  parameter int NUM_KEYS = 10,
  localparam int KEY_W   = $clog2(NUM_KEYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             edgeMode,
  input  logic [2:0]       spacingCode,
  input  logic             burstDone,
  input  logic             commBusy,
  input  logic             syncIn,
  output logic [KEY_W-1:0] keyIdx,
  output logic             burstStart,
  output logic             syncPullLow
);

  scanCtrl_t ctrl;
  scanStat_t stat;

  scan_timer_dp #(.TICK_DIV(TICK_DIV)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .spacingCode (spacingCode),
    .burstDone   (burstDone),
    .syncIn      (syncIn),
    .stat        (stat)
  );

  scan_ctrl #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .edgeMode    (edgeMode),
    .commBusy    (commBusy),
    .stat        (stat),
    .ctrl        (ctrl),
    .keyIdx      (keyIdx),
    .burstStart  (burstStart),
    .syncPullLow (syncPullLow)
  );

endmodule

// File: tb/test_key_scan_sequencer.sv
module test_key_scan_sequencer;

  localparam int TDIV = 3;
  localparam int NK   = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       edgeMode = 1'b0;
  logic [2:0] spacingCode = 3'd2;
  logic       burstDone = 1'b0;
  logic       commBusy = 1'b0;
  logic       extHold = 1'b1;
  logic       edgeDrive = 1'b0;
  logic       syncIn;
  logic [3:0] keyIdx;
  logic       burstStart;
  logic       syncPullLow;

  assign syncIn = edgeMode ? edgeDrive : !(syncPullLow || extHold);

  always #2 clk = ~clk;

  key_scan_sequencer #(.TICK_DIV(TDIV), .NUM_KEYS(NK)) i_key_scan_sequencer (
    .clk(clk), .rstN(rstN), .edgeMode(edgeMode), .spacingCode(spacingCode),
    .burstDone(burstDone), .commBusy(commBusy), .syncIn(syncIn),
    .keyIdx(keyIdx), .burstStart(burstStart), .syncPullLow(syncPullLow)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  function automatic int unitsExp(input int code);
    case (code)
      0: return 4;  1: return 5;  2: return 6;  3: return 7;
      4: return 8;  5: return 10; 6: return 12; default: return 14;
    endcase
  endfunction

  function automatic int intervalExp(input int code, input int d);
    int base = unitsExp(code) * TDIV;
    return (d + 1 > base) ? d + 1 : base;
  endfunction

  // monitor and burst-done responder
  int cyc = 0, lastStart = 0, prevKey = -1, prevCode = 2, prevD = 0;
  int startCount = 0, doneCnt = 0;
  bit doneArmed = 0, prevWasStart = 0, prevPull = 0, freeWrap = 0;

  always @(negedge clk) begin
    cyc++;
    burstDone = 1'b0;
    if (rstN) begin
      if (prevWasStart) chk(!burstStart, "R9", int'(burstStart), 0);
      if (syncPullLow !== prevPull)
        chk(burstStart || (keyIdx == 0 && prevKey == NK - 1), "R10",
            int'(syncPullLow), int'(prevPull));
      prevPull = syncPullLow;
      prevWasStart = burstStart;
      if (burstStart) begin
        if (prevKey >= 0 && prevKey != NK - 1) begin
          chk(int'(keyIdx) == prevKey + 1, "R1", int'(keyIdx), prevKey + 1);
          chk(cyc - lastStart == intervalExp(prevCode, prevD),
              (prevD + 1 > unitsExp(prevCode) * TDIV) ? "R3" : "R2",
              cyc - lastStart, intervalExp(prevCode, prevD));
        end else if (prevKey == NK - 1 && !edgeMode && freeWrap) begin
          chk(keyIdx == 0, "R1", int'(keyIdx), 0);
          chk(cyc - lastStart == intervalExp(prevCode, prevD) + 3, "R5",
              cyc - lastStart, intervalExp(prevCode, prevD) + 3);
        end
        chk(syncPullLow == (!edgeMode && keyIdx != 0), edgeMode ? "R6" : "R4",
            int'(syncPullLow), int'(!edgeMode && keyIdx != 0));
        startCount++;
        prevKey   = int'(keyIdx);
        lastStart = cyc;
        prevCode  = int'(spacingCode);
        prevD     = $urandom_range(unitsExp(prevCode) * TDIV + 15, 0);
        doneCnt   = prevD;
        doneArmed = 1'b1;
        if (keyIdx == NK - 1) spacingCode = 3'($urandom_range(7, 0));
      end
      if (doneArmed) begin
        if (doneCnt == 0) begin
          burstDone = 1'b1;
          doneArmed = 1'b0;
        end else doneCnt--;
      end
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitKey(input int k);
    do @(negedge clk); while (!(burstStart && keyIdx == k));
  endtask

  initial begin
    #(4 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    waitCycles(4);
    // R8 reset state
    chk(keyIdx == 0, "R8", int'(keyIdx), 0);
    chk(burstStart == 0, "R8", int'(burstStart), 0);
    chk(syncPullLow == 0, "R8", int'(syncPullLow), 0);
    rstN = 1'b1;

    // R5: another device holds the line low
    waitCycles(20);
    chk(startCount == 0, "R5", startCount, 0);
    extHold = 1'b0;
    waitCycles(3);
    chk(burstStart && keyIdx == 0, "R5", int'(burstStart), 1);

    // free-running level scans with random codes and burst lengths
    freeWrap = 1'b1;
    do @(negedge clk); while (startCount < 1 + 3 * NK);

    // R7: busy held across a level start
    waitKey(5);
    freeWrap = 1'b0;
    extHold  = 1'b1;
    commBusy = 1'b1;
    waitCycles(400);
    base = startCount;
    extHold = 1'b0;
    waitCycles(10);
    chk(startCount == base, "R7", startCount, base);
    commBusy = 1'b0;
    @(negedge clk);
    chk(burstStart && keyIdx == 0, "R7", int'(burstStart), 1);

    // switch to edge mode while idle
    waitKey(5);
    extHold = 1'b1;
    waitCycles(400);
    edgeDrive = 1'b0;
    edgeMode  = 1'b1;
    waitCycles(10);
    for (int i = 0; i < 3; i++) begin
      base = startCount;
      edgeDrive = 1'b0;
      waitCycles(4);
      edgeDrive = 1'b1;
      waitCycles(3);
      chk(burstStart && keyIdx == 0, "R6", int'(burstStart), 1);
      // toggle during the scan: must be ignored
      waitKey(3);
      edgeDrive = 1'b0;
      waitCycles(4);
      edgeDrive = 1'b1;
      waitCycles(700);
      chk(startCount == base + NK, "R6", startCount - base, NK);
      chk(keyIdx == 0 && syncPullLow == 0, "R1", int'(keyIdx), 0);
    end

    // R7: edge seen while busy stays pending
    base = startCount;
    commBusy  = 1'b1;
    edgeDrive = 1'b0;
    waitCycles(4);
    edgeDrive = 1'b1;
    waitCycles(20);
    chk(startCount == base, "R7", startCount, base);
    commBusy = 1'b0;
    @(negedge clk);
    chk(burstStart && keyIdx == 0, "R7", int'(burstStart), 1);
    waitCycles(700);
    chk(startCount == base + NK, "R1", startCount - base, NK);

    finishRun();
  end

endmodule